// File: doc/BRIEF.md
# Fault Escalation and Lockup Unit

This unit gathers the individual fault strobes raised by a processor core and merges them into one pending hard-fault exception request. That request outranks every exception source except the non-maskable interrupt. The unit also watches the core's current execution context. A fault seen while the core is already running the NMI handler or the hard-fault handler cannot be handled by another exception. Such a fault escalates to a locked-up state, which stalls instruction fetch until a reset arrives or an NMI is accepted.

A sticky one-hot cause register records every qualified fault source that has fired. Software clears its bits by writing ones. A breakpoint counts as a fault only while no debugger is attached. Otherwise it goes to the debug logic on a separate output. The exception arbitration here is reduced to picking the winner among NMI, hard fault and the other pending exceptions. Vector fetch and stacking belong to the core.

Top module: `fault_escalator`

## Requirements
- R1: `fault_strobe` bit positions are: 0 SVC priority error, 1 breakpoint, 2 system bus error, 3 fetch from a no-execute region, 4 undefined instruction, 5 unaligned load/store. Each qualified strobe sets the same bit of `fault_cause` on the next clock edge, and that bit stays set until it is cleared.
- R2: A qualified fault in context thread (0) or other handler (1) raises `hf_req` from the next edge, provided the core is not locked. The request stays high until the edge at which `exec_ctx` reads hard-fault handler (2).
- R3: While `dbg_attached` is high, strobe bit 1 is not a fault: it sets no cause bit and raises no request. It appears as `bkpt_to_debug` in the same cycle instead.
- R4: `exc_grant` encodes 0 none, 1 NMI, 2 hard fault, 3 other. The priority order is `nmi_req` first, then a pending hard fault, then `irq_pend`.
- R5: A qualified fault in context hard-fault handler (2) or NMI handler (3) sets `core_locked` on the next edge and leaves `hf_req` low.
- R6: While `core_locked` is high, `hf_req` stays low and new faults raise no request. `exc_grant` is none unless `nmi_req` is high. The lock holds until `rst` or `nmi_req`.
- R7: `nmi_req` high while locked clears `core_locked` at that clock edge.
- R8: Ones on `cause_clr` clear the matching `fault_cause` bits. A bit that is set and cleared in the same cycle ends up set.
- R9: Several strobes in one cycle raise a single request and record all of their causes together.
- R10: Synchronous reset `rst` zeroes `fault_cause`, `hf_req` and `core_locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_strobe | input | 6 | One-cycle fault indications, bit map in R1 |
| dbg_attached | input | 1 | A debugger is attached |
| exec_ctx | input | 2 | 0 thread, 1 other handler, 2 hard-fault handler, 3 NMI handler |
| nmi_req | input | 1 | NMI request, taken as accepted in the cycle it is high |
| irq_pend | input | 1 | Some lower-priority exception is pending |
| cause_clr | input | 6 | Write-one-to-clear mask for the cause register |
| hf_req | output | 1 | Pending hard-fault exception request |
| core_locked | output | 1 | Lockup state; stalls instruction fetch |
| exc_grant | output | 2 | Winning exception, encoded as in R4 |
| fault_cause | output | 6 | Sticky one-hot record of fault causes |
| bkpt_to_debug | output | 1 | Breakpoint routed to the debug logic |

## Verification
The assertions assume the core reports the hard-fault handler context only after a request has been raised. They also assume fault strobes are single-cycle pulses from a core that is not stalled. The stimulus never presents a breakpoint and another source together while a debugger is attached. Each input vector is held for exactly one clock, and the context always moves in the order the core would use: thread, then the handler, then back.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;

    localparam int FLT_W    = 6;
    localparam int BKPT_IDX = 1;
    localparam int CTX_W    = 2;

    typedef enum logic [CTX_W-1:0] {
        CTX_THREAD    = 2'd0,
        CTX_HANDLER   = 2'd1,
        CTX_HARDFAULT = 2'd2,
        CTX_NMI       = 2'd3
    } ctx_e;

    typedef enum logic [1:0] {
        GNT_NONE      = 2'd0,
        GNT_NMI       = 2'd1,
        GNT_HARDFAULT = 2'd2,
        GNT_OTHER     = 2'd3
    } grant_e;

    typedef struct packed {
        logic [FLT_W-1:0] vec;
        logic             any;
        logic             critical;
    } fault_info_t;

    function automatic logic ctx_is_critical(ctx_e c);
        return (c == CTX_HARDFAULT) || (c == CTX_NMI);
    endfunction

endpackage

// File: rtl/fault_qualify.sv
module fault_qualify
    import fault_esc_pkg::*;
#(
    parameter int W    = FLT_W,
    parameter int BKPT = BKPT_IDX
) (
    input  logic [W-1:0] strobe,
    input  logic         dbg_attached,
    input  ctx_e         ctx,
    output fault_info_t  info,
    output logic         bkpt_dbg
);
    logic [W-1:0] masked;

    for (genvar i = 0; i < W; i++) begin : g_mask
        if (i == BKPT) begin : g_bkpt
            assign masked[i] = strobe[i] & ~dbg_attached;
        end else begin : g_plain
            assign masked[i] = strobe[i];
        end
    end

    assign bkpt_dbg      = strobe[BKPT] & dbg_attached;
    assign info.vec      = masked;
    assign info.any      = |masked;
    assign info.critical = ctx_is_critical(ctx);
endmodule

// File: rtl/fault_cause_reg.sv
module fault_cause_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] cause
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                cause[i] <= 1'b0;
            else if (set_vec[i])
                cause[i] <= 1'b1;
            else if (clr_vec[i])
                cause[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/lockup_ctrl.sv
module lockup_ctrl
    import fault_esc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  fault_info_t info,
    input  ctx_e        ctx,
    input  logic        nmi_req,
    output logic        hf_pend,
    output logic        locked
);
    logic lock_set;
    logic hf_set;

    assign lock_set = info.any &  info.critical & ~locked;
    assign hf_set   = info.any & ~info.critical & ~locked;

    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b0;
        else if (locked && nmi_req)
            locked <= 1'b0;
        else if (lock_set)
            locked <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            hf_pend <= 1'b0;
        else if (lock_set)
            hf_pend <= 1'b0;
        else if (hf_set)
            hf_pend <= 1'b1;
        else if (ctx == CTX_HARDFAULT)
            hf_pend <= 1'b0;
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import fault_esc_pkg::*;
(
    input  logic   nmi_req,
    input  logic   locked,
    input  logic   hf_pend,
    input  logic   irq_pend,
    output grant_e grant
);
    always_comb begin
        if (nmi_req)
            grant = GNT_NMI;
        else if (locked)
            grant = GNT_NONE;
        else if (hf_pend)
            grant = GNT_HARDFAULT;
        else if (irq_pend)
            grant = GNT_OTHER;
        else
            grant = GNT_NONE;
    end
endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
    import fault_esc_pkg::*;
#(
    parameter int NSRC = FLT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] fault_strobe,
    input  logic            dbg_attached,
    input  logic [1:0]      exec_ctx,
    input  logic            nmi_req,
    input  logic            irq_pend,
    input  logic [NSRC-1:0] cause_clr,
    output logic            hf_req,
    output logic            core_locked,
    output logic [1:0]      exc_grant,
    output logic [NSRC-1:0] fault_cause,
    output logic            bkpt_to_debug
);
    ctx_e        ctx;
    fault_info_t info;
    grant_e      grant;

    assign ctx = ctx_e'(exec_ctx);

    fault_qualify #(.W(NSRC), .BKPT(BKPT_IDX)) u_qual (
        .strobe       (fault_strobe),
        .dbg_attached (dbg_attached),
        .ctx          (ctx),
        .info         (info),
        .bkpt_dbg     (bkpt_to_debug)
    );

    fault_cause_reg #(.W(NSRC)) u_cause (
        .clk     (clk),
        .rst     (rst),
        .set_vec (info.vec),
        .clr_vec (cause_clr),
        .cause   (fault_cause)
    );

    lockup_ctrl u_lock (
        .clk     (clk),
        .rst     (rst),
        .info    (info),
        .ctx     (ctx),
        .nmi_req (nmi_req),
        .hf_pend (hf_req),
        .locked  (core_locked)
    );

    exc_arbiter u_arb (
        .nmi_req  (nmi_req),
        .locked   (core_locked),
        .hf_pend  (hf_req),
        .irq_pend (irq_pend),
        .grant    (grant)
    );

    assign exc_grant = grant;
endmodule

// File: rtl/fault_escalator_chk.sv
module fault_escalator_chk #(
    parameter int NSRC = 6,
    parameter int BK   = 1
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] fault_strobe,
    input logic            dbg_attached,
    input logic [1:0]      exec_ctx,
    input logic            nmi_req,
    input logic [NSRC-1:0] cause_clr,
    input logic            hf_req,
    input logic            core_locked,
    input logic [1:0]      exc_grant,
    input logic [NSRC-1:0] fault_cause
);
    logic [NSRC-1:0] bk_mask;
    logic            qual;
    logic            crit;

    assign bk_mask = dbg_attached ? (NSRC'(1) << BK) : '0;
    assign qual    = |(fault_strobe & ~bk_mask);
    assign crit    = exec_ctx[1];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (fault_cause == '0 && !hf_req && !core_locked)); // R10

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fault_cause & ($past(fault_cause) & ~$past(cause_clr)))
                  == ($past(fault_cause) & ~$past(cause_clr)))); // R1

    AST_HF_RAISE: assert property (@(posedge clk) disable iff (rst)
        (qual && !crit && !core_locked) |=> hf_req); // R2

    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (qual && crit && !core_locked) |=> (core_locked && !hf_req)); // R5

    AST_LOCK_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        core_locked |-> !hf_req); // R6

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (core_locked && !nmi_req) |=> core_locked); // R6

    AST_NMI_EXIT: assert property (@(posedge clk) disable iff (rst)
        (core_locked && nmi_req) |=> !core_locked); // R7

    AST_NMI_WINS: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> (exc_grant == 2'd1)); // R4
endmodule

bind fault_escalator fault_escalator_chk #(.NSRC(NSRC), .BK(fault_esc_pkg::BKPT_IDX)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fault_strobe (fault_strobe),
    .dbg_attached (dbg_attached),
    .exec_ctx     (exec_ctx),
    .nmi_req      (nmi_req),
    .cause_clr    (cause_clr),
    .hf_req       (hf_req),
    .core_locked  (core_locked),
    .exc_grant    (exc_grant),
    .fault_cause  (fault_cause)
);

// File: tb/fault_escalator_bench.sv
module fault_escalator_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] fault_strobe = '0;
    logic       dbg_attached = 1'b0;
    logic [1:0] exec_ctx = '0;
    logic       nmi_req = 1'b0;
    logic       irq_pend = 1'b0;
    logic [5:0] cause_clr = '0;
    logic       hf_req;
    logic       core_locked;
    logic [1:0] exc_grant;
    logic [5:0] fault_cause;
    logic       bkpt_to_debug;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        logic       hf;
        logic       lk;
        logic [1:0] gnt;
        logic [5:0] cause;
        logic       bk;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    fault_escalator u_fault_escalator (
        .clk           (clk),
        .rst           (rst),
        .fault_strobe  (fault_strobe),
        .dbg_attached  (dbg_attached),
        .exec_ctx      (exec_ctx),
        .nmi_req       (nmi_req),
        .irq_pend      (irq_pend),
        .cause_clr     (cause_clr),
        .hf_req        (hf_req),
        .core_locked   (core_locked),
        .exc_grant     (exc_grant),
        .fault_cause   (fault_cause),
        .bkpt_to_debug (bkpt_to_debug)
    );

    task automatic step(input logic r, input logic [5:0] f, input logic d,
                        input logic [1:0] c, input logic n, input logic q,
                        input logic [5:0] clr, input logic e_hf, input logic e_lk,
                        input logic [1:0] e_g, input logic [5:0] e_c,
                        input logic e_bk, input string tag);
        exp_t it;
        @(negedge clk);
        rst = r; fault_strobe = f; dbg_attached = d; exec_ctx = c;
        nmi_req = n; irq_pend = q; cause_clr = clr;
        it.hf = e_hf; it.lk = e_lk; it.gnt = e_g; it.cause = e_c;
        it.bk = e_bk; it.tag = tag;
        sb.push_back(it);
    endtask

    always @(posedge clk) begin
        #5;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if (hf_req !== it.hf || core_locked !== it.lk || exc_grant !== it.gnt ||
                fault_cause !== it.cause || bkpt_to_debug !== it.bk) begin
                errors++;
                $display("FAIL %s: got hf=%b lk=%b gnt=%0d cause=%h bk=%b, expected hf=%b lk=%b gnt=%0d cause=%h bk=%b",
                         it.tag, hf_req, core_locked, exc_grant, fault_cause, bkpt_to_debug,
                         it.hf, it.lk, it.gnt, it.cause, it.bk);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        //   rst fault   dbg ctx nmi irq clr     hf lk g  cause   bk
        step(0, 6'h00, 0, 0, 0, 0, 6'h00,  0, 0, 0, 6'h00, 0, "R10 reset state");
        step(0, 6'h00, 0, 0, 0, 1, 6'h00,  0, 0, 3, 6'h00, 0, "R4 other exception alone");
        step(0, 6'h04, 0, 0, 0, 1, 6'h00,  1, 0, 2, 6'h04, 0, "R2 R1 bus fault in thread");
        step(0, 6'h00, 0, 0, 1, 1, 6'h00,  1, 0, 1, 6'h04, 0, "R4 NMI over hard fault");
        step(0, 6'h00, 0, 2, 0, 0, 6'h00,  0, 0, 0, 6'h04, 0, "R2 request drops on handler entry");
        step(0, 6'h00, 0, 0, 0, 0, 6'h04,  0, 0, 0, 6'h00, 0, "R8 write-one clear");
        step(0, 6'h02, 1, 0, 0, 0, 6'h00,  0, 0, 0, 6'h00, 1, "R3 breakpoint with debugger");
        step(0, 6'h02, 0, 0, 0, 0, 6'h00,  1, 0, 2, 6'h02, 0, "R3 breakpoint without debugger");
        step(0, 6'h39, 0, 0, 0, 0, 6'h00,  1, 0, 2, 6'h3B, 0, "R9 several strobes");
        step(0, 6'h00, 0, 2, 0, 0, 6'h3B,  0, 0, 0, 6'h00, 0, "R9 single request taken");
        step(0, 6'h10, 0, 2, 0, 0, 6'h00,  0, 1, 0, 6'h10, 0, "R5 fault in hard-fault handler");
        step(0, 6'h04, 0, 0, 0, 1, 6'h00,  0, 1, 0, 6'h14, 0, "R6 locked blocks request and grant");
        step(0, 6'h00, 0, 0, 1, 0, 6'h00,  0, 0, 1, 6'h14, 0, "R7 NMI ends lockup");
        step(0, 6'h01, 0, 3, 0, 0, 6'h01,  0, 1, 0, 6'h15, 0, "R5 R8 fault in NMI handler, set beats clear");
        step(1, 6'h00, 0, 0, 0, 0, 6'h00,  0, 0, 0, 6'h00, 0, "R10 R6 reset ends lockup");
        step(0, 6'h20, 0, 1, 0, 0, 6'h00,  1, 0, 2, 6'h20, 0, "R2 fault in other handler");
        step(0, 6'h00, 0, 2, 0, 0, 6'h00,  0, 0, 0, 6'h20, 0, "R2 handler entered");
        @(negedge clk);
        fault_strobe = '0; cause_clr = '0; exec_ctx = 2'd0;
        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule